// File: doc/BRIEF.md
# Cascaded Counter Pair with Coherent Timestamp Capture

The block joins two equal-width counters into one counter of twice the width. The low half advances on a tick taken from the clock through a fixed divider, counts from zero up to its programmed limit and then returns to zero. Each time it does so, it raises a one-cycle overflow pulse, and that pulse is the only thing that advances the high half. The high half counts the same way up to its own limit. With both limits at their maximum the pair wraps at 2^(2*HALF_W), which is 2^32 for the default 16-bit halves.

An external capture strobe records a timestamp of the whole counter. The low half is stored in the cycle the strobe is sampled. The high half is stored one cycle later, when any carry that was still pending from the low half has landed. The stored value therefore always matches the count in the strobe cycle. The same carry correction is applied to the live count output, so software or logic that reads the count never sees a new low half paired with an old high half.

A valid flag shows that a stored timestamp is waiting. A read strobe takes it. A strobe that arrives before the previous value is read sets a sticky overrun flag and leaves the stored value untouched.

Top module: `casc32_capture`

## Requirements
- R1: While rst_n is low and after it is released, count, cap_val, lo_ovf, cap_valid and cap_ovr are all zero until the first tick or strobe.
- R2: A tick occurs once every PRESC clock cycles in which en is high. Cycles with en low neither produce a tick nor advance the divider, so count holds its value.
- R3: On each tick the low half (count bits HALF_W-1:0) increments. When it equals per_lo, it returns to 0 instead. lo_ovf is high for exactly the one cycle after such a return.
- R4: The high half (count bits 2*HALF_W-1:HALF_W) changes only on a low-half overflow. It increments then, and returns to 0 when it equals per_hi. With both limits all ones, count wraps from all ones to zero.
- R5: After n ticks since reset, count equals {(n/(per_lo+1)) mod (per_hi+1), n mod (per_lo+1)} in every cycle, including the cycle right after a low-half wrap.
- R6: A strobe sampled in cycle t stores the value count had in cycle t. cap_valid is still low in cycle t+1 and rises in cycle t+2, and cap_val holds the stored value from then on.
- R7: cap_rd clears cap_valid and cap_ovr at the next edge. A strobe in the same cycle as cap_rd, while a value is valid, is accepted as a new capture.
- R8: A strobe that arrives while a value is valid and unread, or while a capture is still completing, sets cap_ovr and leaves cap_val unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable, gates the divider |
| per_lo | input | HALF_W | Last value of the low half before it wraps |
| per_hi | input | HALF_W | Last value of the high half before it wraps |
| cap_stb | input | 1 | Capture strobe |
| cap_rd | input | 1 | Acknowledges the stored timestamp |
| count | output | 2*HALF_W | Live count, corrected for a pending carry |
| lo_ovf | output | 1 | One-cycle low-half overflow event |
| cap_val | output | 2*HALF_W | Stored timestamp |
| cap_valid | output | 1 | Stored timestamp is waiting to be read |
| cap_ovr | output | 1 | A capture was lost to an unread value |

## Verification
The live count is compared every cycle against a value computed from the number of enabled cycles. This is done with both limits at maximum, which walks through a full 2^8 wrap of a 4-bit-half build, and again with small uneven limits, where a swapped half or a wrong wrap point shows at once. Captures are fired with gaps that rotate through every divider phase and low-half value, so some of them land exactly in the cycle where a carry is still pending. Those cases separate a correct delayed high-half sample from a split timestamp. Separate sequences cover an unread value, back-to-back strobes and a strobe coinciding with a read; each one tells overrun handling apart from overwriting.

// File: rtl/casc32_capture.sv
module casc32_capture #(
  parameter int HALF_W = 16,
  parameter int PRESC  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [HALF_W-1:0]     per_lo,
  input  logic [HALF_W-1:0]     per_hi,
  input  logic                  cap_stb,
  input  logic                  cap_rd,
  output logic [2*HALF_W-1:0]   count,
  output logic                  lo_ovf,
  output logic [2*HALF_W-1:0]   cap_val,
  output logic                  cap_valid,
  output logic                  cap_ovr
);
  localparam int FULL_W = 2 * HALF_W;

  logic              tick;
  logic [HALF_W-1:0] lo_q, hi_q, cap_lo_q, cap_hi_q, hi_inc, hi_live;
  logic              ovf_q, pend_q, valid_q, ovr_q;
  logic              accept, overrun;

  generate
    if (PRESC > 1) begin : g_div
      localparam int PW = $clog2(PRESC);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) div_q <= '0;
        else if (en) div_q <= (div_q == PW'(PRESC - 1)) ? '0 : div_q + 1'b1;
      assign tick = en && (div_q == PW'(PRESC - 1));
    end else begin : g_nodiv
      assign tick = en;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= tick && (lo_q == per_lo);
      if (tick) lo_q <= (lo_q == per_lo) ? '0 : lo_q + 1'b1;
    end

  assign hi_inc  = (hi_q == per_hi) ? '0 : hi_q + 1'b1;
  assign hi_live = ovf_q ? hi_inc : hi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_q <= '0;
    else if (ovf_q) hi_q <= hi_inc;

  assign accept  = cap_stb && !pend_q && (!valid_q || cap_rd);
  assign overrun = cap_stb && !accept;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
      pend_q   <= 1'b0;
      valid_q  <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      pend_q  <= accept;
      valid_q <= pend_q || (valid_q && !cap_rd);
      ovr_q   <= overrun || (ovr_q && !cap_rd);
      if (accept) cap_lo_q <= lo_q;
      if (pend_q) cap_hi_q <= hi_q;
    end

  assign count     = {hi_live, lo_q};
  assign lo_ovf    = ovf_q;
  assign cap_val   = {cap_hi_q, cap_lo_q};
  assign cap_valid = valid_q;
  assign cap_ovr   = ovr_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ovf_q) |=> $stable(count));

  a_r3_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lo_q == per_lo) |=> (lo_q == '0 && lo_ovf));

  a_r4_hi_only_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_q |=> $stable(hi_q));

  a_r6_coherent_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> (cap_val == FULL_W'($past(count, 2))));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rd && !cap_stb && !pend_q) |=> (!cap_valid && !cap_ovr));

  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && valid_q && !cap_rd) |=> (cap_ovr && $stable(cap_val)));
endmodule

// File: tb/casc32_capture_bench.sv
module casc32_capture_bench;
  localparam int HW = 4;
  localparam int PR = 2;

  logic          clk = 1'b0;
  logic          rst_n, en, cap_stb, cap_rd;
  logic [HW-1:0] per_lo, per_hi;
  logic [2*HW-1:0] count, cap_val;
  logic          lo_ovf, cap_valid, cap_ovr;

  int checks = 0;
  int failures = 0;
  longint k;

  always #5 clk = ~clk;

  casc32_capture #(.HALF_W(HW), .PRESC(PR)) u_casc32_capture (
    .clk(clk), .rst_n(rst_n), .en(en), .per_lo(per_lo), .per_hi(per_hi),
    .cap_stb(cap_stb), .cap_rd(cap_rd), .count(count), .lo_ovf(lo_ovf),
    .cap_val(cap_val), .cap_valid(cap_valid), .cap_ovr(cap_ovr));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) k <= 0;
    else if (en) k <= k + 1;

  function automatic longint expect_count(longint kk);
    longint n = kk / PR;
    longint lo = n % (longint'(per_lo) + 1);
    longint hi = (n / (longint'(per_lo) + 1)) % (longint'(per_hi) + 1);
    return (hi << HW) | lo;
  endfunction

  function automatic bit expect_ovf(longint kk);
    longint n = kk / PR;
    return (kk > 0) && (kk % PR == 0) && (n % (longint'(per_lo) + 1) == 0);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cfg(logic [HW-1:0] pl, logic [HW-1:0] ph);
    rst_n = 1'b0; en = 1'b0; cap_stb = 1'b0; cap_rd = 1'b0;
    per_lo = pl; per_hi = ph;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic sweep(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R5 count", count, expect_count(k));
      check("R3 lo_ovf", lo_ovf, expect_ovf(k));
    end
  endtask

  task automatic captures(int num);
    for (int i = 0; i < num; i++) begin
      longint e;
      repeat (i % 5) @(negedge clk);
      e = expect_count(k);
      cap_stb = 1'b1;
      @(negedge clk);
      cap_stb = 1'b0;
      check("R6 valid low one cycle after strobe", cap_valid, 0);
      @(negedge clk);
      check("R6 valid rises", cap_valid, 1);
      check("R6 captured value", cap_val, e);
      cap_rd = 1'b1;
      @(negedge clk);
      cap_rd = 1'b0;
      check("R7 read clears valid", cap_valid, 0);
    end
  endtask

  task automatic overrun_cases();
    longint e1, e2;
    e1 = expect_count(k);
    cap_stb = 1'b1;
    @(negedge clk);
    cap_stb = 1'b0;
    @(negedge clk);
    cap_stb = 1'b1;
    @(negedge clk);
    cap_stb = 1'b0;
    check("R8 overrun on unread", cap_ovr, 1);
    check("R8 value kept", cap_val, e1);
    check("R8 still valid", cap_valid, 1);
    repeat (3) @(negedge clk);
    check("R8 value kept later", cap_val, e1);
    cap_rd = 1'b1;
    @(negedge clk);
    cap_rd = 1'b0;
    check("R7 read clears overrun", cap_ovr, 0);
    check("R7 read clears valid", cap_valid, 0);

    e1 = expect_count(k);
    cap_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cap_stb = 1'b0;
    check("R8 back-to-back overrun", cap_ovr, 1);
    check("R8 back-to-back keeps first", cap_val, e1);
    check("R8 back-to-back valid", cap_valid, 1);

    e2 = expect_count(k);
    cap_stb = 1'b1;
    cap_rd = 1'b1;
    @(negedge clk);
    cap_stb = 1'b0;
    cap_rd = 1'b0;
    check("R7 read with strobe clears valid", cap_valid, 0);
    check("R7 read with strobe clears overrun", cap_ovr, 0);
    @(negedge clk);
    check("R7 strobe with read accepted", cap_valid, 1);
    check("R7 strobe with read value", cap_val, e2);
    check("R7 no overrun", cap_ovr, 0);
    cap_rd = 1'b1;
    @(negedge clk);
    cap_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; cap_stb = 1'b0; cap_rd = 1'b0;
    per_lo = '1; per_hi = '1;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count, 0);
    check("R1 cap_val in reset", cap_val, 0);
    check("R1 flags in reset", {lo_ovf, cap_valid, cap_ovr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after release", count, 0);

    start_cfg('1, '1);
    sweep(600);
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 hold while disabled", count, expect_count(k));
    end
    en = 1'b1;
    sweep(50);
    captures(60);
    overrun_cases();
    sweep(20);

    start_cfg(4'd2, 4'd3);
    sweep(100);
    captures(40);
    overrun_cases();
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 hold small periods", count, expect_count(k));
    end
    en = 1'b1;
    sweep(30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule